// File: doc/BRIEF.md
# Strobe-Timed Bus Cycle Terminator

This block is the slave side of an asynchronous, strobe-framed bus. A master opens a cycle by pulling an active-low address strobe low and holds it low until the cycle is terminated. On the rising clock edge that first sees the strobe low, the block decodes the upper address bits into one of several regions. Each region has its own port width, wait count and write permission. The block then counts whole clocks and terminates the cycle. It does this either with a width-coded pair of active-low acknowledge lines or with an active-low bus error. The outputs come from registers, so they are settled long before the master samples them on the falling edge.

A region with no port width is unmapped. A write to a region marked read-only is refused. In both cases a bus error is raised after a fixed timeout, so the master never hangs. Separately, a monitor counts how long the strobe has stayed low. When the strobe stays low past a threshold that is longer than any legal cycle, the monitor emits a one-clock trigger pulse for an external logic analyser.

Top module: `bus_cycle_term`

## Requirements
- R1: A cycle starts at the first rising edge where `as_n` is sampled low while the block is idle (call it edge E0). No termination line is asserted before that edge.
- R2: For a mapped, permitted access, the acknowledge appears in the outputs updated at edge E(W), where W is the wait count of the region. W=0 means it appears right after E0. Defaults for regions 0..7 are 0,1,3,2,-,5,0,-.
- R3: Acknowledge encoding, active low: a 32-bit port (width code 3) drives both `dsack1_n` and `dsack0_n` low. A 16-bit port (code 2) drives only `dsack1_n` low. An 8-bit port (code 1) drives only `dsack0_n` low. By default regions 0 and 3 are 32-bit, regions 1 and 5 are 16-bit, and regions 2 and 6 are 8-bit.
- R4: An access to an unmapped region (width code 0; regions 4 and 7 by default) asserts `berr_n` low, and no acknowledge, at edge E(BERR_TMO). The default BERR_TMO is 6.
- R5: A write (`rw`=0) to a read-only region (regions 3 and 6 by default) is terminated with `berr_n` at E(BERR_TMO). A read of the same region is acknowledged normally.
- R6: A termination stays asserted while the strobe is low. It is released in the outputs updated at the first rising edge that samples `as_n` high.
- R7: If the strobe is negated before the termination, the cycle is abandoned, and no termination line asserts afterwards.
- R8: `stall_trig` is high for exactly one clock, after the STALL_CLKS-th consecutive rising edge with the strobe low. The default STALL_CLKS is 16. It never fires for shorter strobes.
- R9: While reset is held, all three termination lines are high and `stall_trig` is low.
- R10: `berr_n` and the acknowledge lines are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobe sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | Active-low address strobe from the master |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | REGION_BITS | Upper address bits selecting the region |
| dsack0_n | output | 1 | Active-low acknowledge, low bit of width code |
| dsack1_n | output | 1 | Active-low acknowledge, high bit of width code |
| berr_n | output | 1 | Active-low bus error termination |
| stall_trig | output | 1 | One-clock pulse when the strobe stalls |

## Verification
Some properties are checked by assertions on every clock. Termination is released after the strobe is sampled high. A bus error never coincides with an acknowledge. The stall trigger never lasts two clocks. No termination starts unless the strobe was low at the previous edge. The bench scenarios cover the rest: the exact edge at which each region terminates, the width code it reports, the refusal of writes to read-only regions, abandoned cycles, and the placement of the stall pulse. These depend on the table contents and on counting, which the per-cycle properties do not capture.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_TERM} cyc_state_t;

  localparam logic [1:0] PW_NONE = 2'd0;
  localparam logic [1:0] PW_8    = 2'd1;
  localparam logic [1:0] PW_16   = 2'd2;
  localparam logic [1:0] PW_32   = 2'd3;

  // Active-high acknowledge pair {line1, line0} for a port width code
  function automatic logic [1:0] ack_lines(input logic [1:0] pw);
    case (pw)
      PW_32:   return 2'b11;
      PW_16:   return 2'b10;
      PW_8:    return 2'b01;
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/bct_region_decode.sv
module bct_region_decode #(
  parameter int REGION_BITS = 3,
  parameter int WAIT_W      = 4,
  parameter int CNT_W       = 5,
  parameter int BERR_TMO    = 6,
  parameter logic [(1<<REGION_BITS)*2-1:0]      WIDTH_TABLE = '0,
  parameter logic [(1<<REGION_BITS)*WAIT_W-1:0] WAIT_TABLE  = '0,
  parameter logic [(1<<REGION_BITS)-1:0]        RO_TABLE    = '0
) (
  input  logic [REGION_BITS-1:0] addr,
  input  logic                   rw,
  output logic                   dec_err,
  output logic [1:0]             dec_width,
  output logic [CNT_W-1:0]       dec_delay
);
  function automatic logic [1:0] width_of(input logic [REGION_BITS-1:0] r);
    return WIDTH_TABLE[2*r +: 2];
  endfunction

  function automatic logic [WAIT_W-1:0] waits_of(input logic [REGION_BITS-1:0] r);
    return WAIT_TABLE[WAIT_W*r +: WAIT_W];
  endfunction

  always_comb begin
    dec_width = width_of(addr);
    dec_err   = (dec_width == bct_pkg::PW_NONE) || (RO_TABLE[addr] && !rw);
    dec_delay = dec_err ? CNT_W'(BERR_TMO) : CNT_W'(waits_of(addr));
  end
endmodule

// File: rtl/bct_cycle_fsm.sv
module bct_cycle_fsm #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             as_n,
  input  logic             dec_err,
  input  logic [1:0]       dec_width,
  input  logic [CNT_W-1:0] dec_delay,
  output logic             term_o,
  output logic             err_o,
  output logic [1:0]       width_o
);
  import bct_pkg::*;

  cyc_state_t       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      err_o   <= 1'b0;
      width_o <= PW_NONE;
    end else begin
      case (state)
        ST_IDLE: if (!as_n) begin
          err_o   <= dec_err;
          width_o <= dec_width;
          cnt     <= dec_delay;
          state   <= (dec_delay == '0) ? ST_TERM : ST_WAIT;
        end
        ST_WAIT: begin
          if (as_n)                      state <= ST_IDLE;
          else if (cnt == CNT_W'(1))     state <= ST_TERM;
          else                           cnt   <= cnt - 1'b1;
        end
        ST_TERM: if (as_n) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign term_o = (state == ST_TERM);

  // R1: a termination only begins after the strobe was seen low
  a_r1_term_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_o) |-> $past(!as_n));
endmodule

// File: rtl/bct_stall_monitor.sv
module bct_stall_monitor #(
  parameter int STALL_CLKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_n,
  output logic stall_trig
);
  localparam int STALL_W = $clog2(STALL_CLKS + 1);

  logic [STALL_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || as_n) begin
      low_cnt    <= '0;
      stall_trig <= 1'b0;
    end else begin
      if (low_cnt != STALL_W'(STALL_CLKS)) low_cnt <= low_cnt + 1'b1;
      stall_trig <= (low_cnt == STALL_W'(STALL_CLKS - 1));
    end
  end

  // R8: trigger is a single-clock pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stall_trig |=> !stall_trig);
endmodule

// File: rtl/bus_cycle_term.sv
module bus_cycle_term #(
  parameter int REGION_BITS = 3,
  parameter int WAIT_W      = 4,
  parameter int BERR_TMO    = 6,
  parameter int STALL_CLKS  = 16,
  parameter logic [(1<<REGION_BITS)*2-1:0]      WIDTH_TABLE = 16'h18DB,
  parameter logic [(1<<REGION_BITS)*WAIT_W-1:0] WAIT_TABLE  = 32'h0050_2310,
  parameter logic [(1<<REGION_BITS)-1:0]        RO_TABLE    = 8'h48
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   as_n,
  input  logic                   rw,
  input  logic [REGION_BITS-1:0] addr,
  output logic                   dsack0_n,
  output logic                   dsack1_n,
  output logic                   berr_n,
  output logic                   stall_trig
);
  localparam int CNT_W = $clog2((1 << WAIT_W) + BERR_TMO);

  logic             dec_err;
  logic [1:0]       dec_width;
  logic [CNT_W-1:0] dec_delay;
  logic             term, err;
  logic [1:0]       width;
  logic [1:0]       ack_act;

  bct_region_decode #(
    .REGION_BITS(REGION_BITS), .WAIT_W(WAIT_W), .CNT_W(CNT_W),
    .BERR_TMO(BERR_TMO), .WIDTH_TABLE(WIDTH_TABLE),
    .WAIT_TABLE(WAIT_TABLE), .RO_TABLE(RO_TABLE)
  ) u_dec (
    .addr(addr), .rw(rw), .dec_err(dec_err),
    .dec_width(dec_width), .dec_delay(dec_delay)
  );

  bct_cycle_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .as_n(as_n),
    .dec_err(dec_err), .dec_width(dec_width), .dec_delay(dec_delay),
    .term_o(term), .err_o(err), .width_o(width)
  );

  bct_stall_monitor #(.STALL_CLKS(STALL_CLKS)) u_stall (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .stall_trig(stall_trig)
  );

  assign ack_act  = (term && !err) ? bct_pkg::ack_lines(width) : 2'b00;
  assign dsack0_n = !ack_act[0];
  assign dsack1_n = !ack_act[1];
  assign berr_n   = !(term && err);

  // R6: strobe seen high releases every termination line by the next edge
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> (dsack0_n && dsack1_n && berr_n));

  // R10: bus error and acknowledge are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !berr_n |-> (dsack0_n && dsack1_n));
endmodule

// File: tb/tb_bus_cycle_term.sv
module tb_bus_cycle_term;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       as_n = 1'b1;
  logic       rw = 1'b1;
  logic [2:0] addr = '0;
  logic       dsack0_n, dsack1_n, berr_n, stall_trig;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit trig_seen = 0;

  always #10 clk = ~clk;

  bus_cycle_term dut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .rw(rw), .addr(addr),
    .dsack0_n(dsack0_n), .dsack1_n(dsack1_n), .berr_n(berr_n),
    .stall_trig(stall_trig)
  );

  // vector: [10:8] region, [7] rw, [6:4] expected {berr,ack1,ack0} active, [3:0] edges to termination
  localparam logic [10:0] VEC [12] = '{
    {3'd0, 1'b1, 3'b011, 4'd0},   // R2 R3 32-bit, no wait
    {3'd1, 1'b1, 3'b010, 4'd1},   // R3 16-bit
    {3'd2, 1'b1, 3'b001, 4'd3},   // R3 8-bit
    {3'd3, 1'b1, 3'b011, 4'd2},   // R5 read of read-only ok
    {3'd3, 1'b0, 3'b100, 4'd6},   // R5 write refused
    {3'd4, 1'b1, 3'b100, 4'd6},   // R4 unmapped
    {3'd5, 1'b0, 3'b010, 4'd5},   // R2 writes allowed
    {3'd6, 1'b1, 3'b001, 4'd0},
    {3'd6, 1'b0, 3'b100, 4'd6},   // R5
    {3'd7, 1'b0, 3'b100, 4'd6},   // R4
    {3'd0, 1'b0, 3'b011, 4'd0},
    {3'd2, 1'b0, 3'b001, 4'd3}
  };

  function automatic logic [2:0] active();
    return {~berr_n, ~dsack1_n, ~dsack0_n};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) if (rst_n && stall_trig) trig_seen = 1;

  task automatic run_cycle(input logic [2:0] r, input logic w, input logic [2:0] exp, input int d);
    @(negedge clk);
    addr = r; rw = w; as_n = 1'b0;
    for (int k = 0; k <= d; k++) begin
      @(posedge clk); #2;
      if (k < d) check("R1/R2 early", {1'b0, active()}, 4'b0);
      else       check("R2/R3/R4/R5 term", {1'b0, active()}, {1'b0, exp});
    end
    @(posedge clk); #2;
    check("R6 held", {1'b0, active()}, {1'b0, exp});
    @(negedge clk); as_n = 1'b1;
    @(posedge clk); #2;
    check("R6 release", {1'b0, active()}, 4'b0);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R9 reset", {stall_trig, active()}, 4'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check("R9 after reset", {stall_trig, active()}, 4'b0);

    foreach (VEC[i])
      run_cycle(VEC[i][10:8], VEC[i][7], VEC[i][6:4], int'(VEC[i][3:0]));
    check("R8 no trig short", {3'b0, trig_seen}, 4'b0);

    // R7: abandon a 5-wait cycle after three low edges
    @(negedge clk); addr = 3'd5; rw = 1'b1; as_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); as_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #2;
      check("R7 abandoned", {1'b0, active()}, 4'b0);
    end
    run_cycle(3'd1, 1'b1, 3'b010, 1);

    // R8: hold strobe low on unmapped region for 20 edges
    @(negedge clk); addr = 3'd4; rw = 1'b1; as_n = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #2;
      check("R8 stall trig", {3'b0, stall_trig}, {3'b0, (k == 15)});
      if (k >= 6) check("R4/R10 berr held", {1'b0, active()}, 4'b0100);
    end
    @(negedge clk); as_n = 1'b1;
    @(posedge clk); #2;
    check("R6 release after stall", {stall_trig, active()}, 4'b0);

    // R9: reset during a termination
    run_cycle(3'd0, 1'b1, 3'b011, 0);
    @(negedge clk); addr = 3'd6; as_n = 1'b0;
    @(posedge clk); #2;
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #2;
    check("R9 reset mid-cycle", {stall_trig, active()}, 4'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule